// File: doc/BRIEF.md
# SDRAM Command and Mode Register Decoder

This block sits on the command side of a four-bank synchronous DRAM model or controller front end. On every rising clock edge it samples the chip-select, row strobe, column strobe and write-enable lines together with clock enable, the bank-select bits and the address bus. It turns them into one decoded command strobe, the target bank, and the auto-precharge and all-banks qualifiers. It keeps an open/closed flag for each bank and holds the mode register and the extended mode register. It also tracks the deep power-down state.

Every command is checked against the current state before it takes effect. Four cases are rejected: a command inside the register-load wait window, an access to a closed bank, a register load while any bank is open, and a register value using a reserved code. A rejected command raises a one-cycle illegal flag and changes nothing. After the block leaves deep power-down, reads and writes stay locked out until both registers have been written again.

All outputs are registered. A command sampled at edge n appears on the outputs from edge n and is visible during the cycle that follows.

Top module: `sdr_cmd_decoder`

## Requirements
- R1: With clock enable high and chip select high, the sampled lines produce no strobe, no illegal flag and no change of bank or register state.
- R2: With chip select low, the row-strobe/column-strobe/write-enable codes are decoded as follows: 0/1/1 is activate (its row address appears on the row output and the bank becomes open), and 0/1/0 with address bit 10 low is precharge of the selected bank (that bank becomes closed). The strobe, the bank output and the state change are visible in the cycle after the sampling edge.
- R3: Precharge with address bit 10 high closes every bank and raises the all-banks flag.
- R4: The code 1/0/1 is read and 1/0/0 is write. Address bits 8:0 appear on the column output, and address bit 10 appears on the auto-precharge flag. When that bit is set, the accessed bank is closed.
- R5: Activating a bank that is already open, or reading or writing a closed bank, raises the illegal flag, gives no strobe and changes no state.
- R6: The code 0/0/0 loads a register. Bank bits 00 select the mode register (burst length bits 2:0, interleave bit 3, CAS latency bits 6:4, operating mode bits 8:7, single-write bit 9). Bank bits 10 select the extended register (array coverage bits 2:0, temperature bits 4:3, drive strength bits 6:5). Bank bits 01 and 11 are illegal.
- R7: After reset the mode register reads burst length 000, sequential, CAS latency 011, operating mode 00, single-write 0. The extended register reads coverage 000, temperature 11, drive 00. All banks are closed, and no strobe or illegal flag is raised.
- R8: A register load while any bank is open is illegal and leaves both registers unchanged.
- R9: A register load with a reserved value is illegal and leaves the register unchanged. For the mode register, the reserved values are: operating mode other than 00, CAS latency other than 010 or 011, burst length 100 to 110, burst length 111 with interleave, or any bit above 9 set. For the extended register, they are: coverage 011, 100 or 111, drive 11, or any bit above 6 set.
- R10: After an accepted register load at edge n, any command other than no-operation sampled at edge n+1 is illegal and ignored. Commands are accepted again from edge n+2.
- R11: Deep power-down is entered when clock enable is low and chip select low / row strobe high / column strobe high / write enable low are sampled with all banks idle. While it holds, all inputs are ignored. The edge that samples clock enable high ends it, and the command at that edge is ignored. With clock enable low and any other code, nothing happens.
- R12: The deep power-down code while any bank is open is illegal and does not enter the state.
- R13: After deep power-down, reads and writes are illegal until both the mode register and the extended register have been loaded again. Activate and precharge remain legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address / register value |
| act_o | output | 1 | Activate accepted |
| pre_o | output | 1 | Precharge accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| load_o | output | 1 | Register load accepted |
| bad_o | output | 1 | Illegal command rejected |
| bank_o | output | 2 | Bank of the last accepted bank command |
| auto_pre_o | output | 1 | Last access had auto-precharge |
| all_banks_o | output | 1 | Last precharge targeted all banks |
| col_o | output | 9 | Column of the last access |
| row_o | output | 13 | Row of the last activate |
| bank_open_o | output | 4 | Open flag per bank |
| burst_len_o | output | 3 | Mode register burst length code |
| burst_ilv_o | output | 1 | Mode register interleave select |
| cas_lat_o | output | 3 | Mode register CAS latency code |
| op_mode_o | output | 2 | Mode register operating mode |
| wr_single_o | output | 1 | Mode register single-location write select |
| pasr_o | output | 3 | Extended register array coverage code |
| temp_o | output | 2 | Extended register temperature code |
| drive_o | output | 2 | Extended register drive strength code |
| dpd_o | output | 1 | Deep power-down state |

## Verification
The hardest state to reach from the ports is a legal read that is still refused because only one of the two registers has been reloaded after deep power-down. Getting there takes several steps in order. Every bank must first be closed with an all-banks precharge, so that the power-down code is accepted. Clock enable must then be released on an edge that carries a command, which must be ignored. Next, the mode register is reloaded, and the wait window after it is respected. A bank is then activated and read. That read must be refused. It becomes legal only after the extended register is also reloaded. A reference model in the bench follows the same command stream and predicts every output field on every cycle.

// File: rtl/sdr_dec_pkg.sv
package sdr_dec_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_LOAD,
    CMD_DPD,
    CMD_MISC
  } cmd_t;

  // address bit that carries auto-precharge / all-banks
  localparam int AP_BIT = 10;

  // stored widths of the two configuration registers
  localparam int MR_W  = 10;
  localparam int EMR_W = 7;

  // burst 1, sequential, latency 3, standard mode, burst writes
  localparam logic [MR_W-1:0]  MR_RESET  = 10'b0_00_011_0_000;
  // full array, hottest temperature code, full drive
  localparam logic [EMR_W-1:0] EMR_RESET = 7'b00_11_000;

endpackage

// File: rtl/sdr_cmd_classify.sv
module sdr_cmd_classify
  import sdr_dec_pkg::*;
(
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_t cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cke_i) begin
      if (!cs_n_i && ras_n_i && cas_n_i && !we_n_i) cmd_o = CMD_DPD;
    end else if (!cs_n_i) begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b000:  cmd_o = CMD_LOAD;
        3'b111:  cmd_o = CMD_NOP;
        default: cmd_o = CMD_MISC;
      endcase
    end
  end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
  parameter int BAW = 2,
  localparam int NBANK = 1 << BAW
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             close_all_i,
  input  logic [BAW-1:0]   bank_i,
  output logic [NBANK-1:0] active_o
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk_i) begin
      if (rst_i)                                 active_o[g] <= 1'b0;
      else if (close_all_i)                      active_o[g] <= 1'b0;
      else if (close_i && bank_i == BAW'(g))     active_o[g] <= 1'b0;
      else if (open_i && bank_i == BAW'(g))      active_o[g] <= 1'b1;
    end
  end

  AST_CLOSE_ALL_EMPTIES: assert property (@(posedge clk_i) disable iff (rst_i)
    close_all_i |=> (active_o == '0)); // R3

  AST_NO_OPEN_AND_CLOSE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(open_i && (close_i || close_all_i))); // R2

endmodule

// File: rtl/sdr_mode_regs.sv
module sdr_mode_regs
  import sdr_dec_pkg::*;
#(
  parameter int AW      = 13,
  parameter int MRD_CYC = 2,
  localparam int CW     = $clog2(MRD_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [AW-1:0]    din_i,
  input  logic             ld_mr_i,
  input  logic             ld_emr_i,
  input  logic             forget_i,
  output logic             mr_ok_o,
  output logic             emr_ok_o,
  output logic [MR_W-1:0]  mr_o,
  output logic [EMR_W-1:0] emr_o,
  output logic             busy_o,
  output logic             ready_o
);

  logic [CW-1:0] wait_cnt;
  logic          mr_seen, emr_seen;
  logic [2:0]    f_bl, f_cl, f_cov;
  logic [1:0]    f_op, f_drv;
  logic          f_ilv;

  assign f_bl  = din_i[2:0];
  assign f_ilv = din_i[3];
  assign f_cl  = din_i[6:4];
  assign f_op  = din_i[8:7];
  assign f_cov = din_i[2:0];
  assign f_drv = din_i[6:5];

  // value screening for each register
  always_comb begin
    mr_ok_o = ((din_i >> MR_W) == '0) && (f_op == 2'b00) &&
              (f_cl == 3'd2 || f_cl == 3'd3) &&
              (f_bl <= 3'd3 || (f_bl == 3'd7 && !f_ilv));
    emr_ok_o = ((din_i >> EMR_W) == '0) && (f_drv != 2'b11) &&
               (f_cov == 3'd0 || f_cov == 3'd1 || f_cov == 3'd2 ||
                f_cov == 3'd5 || f_cov == 3'd6);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mr_o  <= MR_RESET;
      emr_o <= EMR_RESET;
    end else begin
      if (ld_mr_i)  mr_o  <= din_i[MR_W-1:0];
      if (ld_emr_i) emr_o <= din_i[EMR_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mr_seen  <= 1'b1;
      emr_seen <= 1'b1;
    end else if (forget_i) begin
      mr_seen  <= 1'b0;
      emr_seen <= 1'b0;
    end else begin
      if (ld_mr_i)  mr_seen  <= 1'b1;
      if (ld_emr_i) emr_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                     wait_cnt <= '0;
    else if (ld_mr_i || ld_emr_i)  wait_cnt <= CW'(MRD_CYC - 1);
    else if (wait_cnt != '0)       wait_cnt <= wait_cnt - 1'b1;
  end

  assign busy_o  = (wait_cnt != '0);
  assign ready_o = mr_seen && emr_seen;

  AST_MR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_mr_i |=> $stable(mr_o)); // R8

  AST_EMR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_emr_i |=> $stable(emr_o)); // R8

  AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ld_mr_i && ld_emr_i)); // R6

  AST_LOAD_OPENS_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_mr_i || ld_emr_i) |=> (busy_o || MRD_CYC < 2)); // R10

  AST_STD_MODE_KEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    mr_o[8:7] == 2'b00); // R9

  AST_FORGET_LOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
    forget_i |=> !ready_o); // R13

endmodule

// File: rtl/sdr_cmd_decoder.sv
module sdr_cmd_decoder
  import sdr_dec_pkg::*;
#(
  parameter int AW      = 13,
  parameter int BAW     = 2,
  parameter int COLW    = 9,
  parameter int MRD_CYC = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   cke_i,
  input  logic                   cs_n_i,
  input  logic                   ras_n_i,
  input  logic                   cas_n_i,
  input  logic                   we_n_i,
  input  logic [BAW-1:0]         ba_i,
  input  logic [AW-1:0]          addr_i,
  output logic                   act_o,
  output logic                   pre_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   load_o,
  output logic                   bad_o,
  output logic [BAW-1:0]         bank_o,
  output logic                   auto_pre_o,
  output logic                   all_banks_o,
  output logic [COLW-1:0]        col_o,
  output logic [AW-1:0]          row_o,
  output logic [(1<<BAW)-1:0]    bank_open_o,
  output logic [2:0]             burst_len_o,
  output logic                   burst_ilv_o,
  output logic [2:0]             cas_lat_o,
  output logic [1:0]             op_mode_o,
  output logic                   wr_single_o,
  output logic [2:0]             pasr_o,
  output logic [1:0]             temp_o,
  output logic [1:0]             drive_o,
  output logic                   dpd_o
);

  localparam logic [BAW-1:0] SEL_MR  = BAW'(0);
  localparam logic [BAW-1:0] SEL_EMR = BAW'(2);

  cmd_t             raw_cmd, eff_cmd;
  logic             a10, all_idle, cur_open;
  logic             busy, ready, mr_ok, emr_ok;
  logic             acc_act, acc_pre, acc_rd, acc_wr, acc_mr, acc_emr, acc_dpd, rej;
  logic             bank_close, bank_close_all;
  logic [MR_W-1:0]  mr_q;
  logic [EMR_W-1:0] emr_q;

  sdr_cmd_classify u_cls (
    .cke_i   (cke_i),
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (raw_cmd)
  );

  assign a10      = addr_i[AP_BIT];
  assign eff_cmd  = dpd_o ? CMD_NOP : raw_cmd;
  assign all_idle = (bank_open_o == '0);
  assign cur_open = bank_open_o[ba_i];

  // legality screen: a rejected command touches nothing
  always_comb begin
    acc_act = 1'b0; acc_pre = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
    acc_mr  = 1'b0; acc_emr = 1'b0; acc_dpd = 1'b0; rej = 1'b0;
    if (eff_cmd != CMD_NOP) begin
      if (busy) begin
        rej = 1'b1;
      end else begin
        case (eff_cmd)
          CMD_ACT: if (cur_open) rej = 1'b1; else acc_act = 1'b1;
          CMD_PRE: acc_pre = 1'b1;
          CMD_RD:  if (cur_open && ready) acc_rd = 1'b1; else rej = 1'b1;
          CMD_WR:  if (cur_open && ready) acc_wr = 1'b1; else rej = 1'b1;
          CMD_LOAD: begin
            if (!all_idle)                       rej = 1'b1;
            else if (ba_i == SEL_MR && mr_ok)    acc_mr = 1'b1;
            else if (ba_i == SEL_EMR && emr_ok)  acc_emr = 1'b1;
            else                                 rej = 1'b1;
          end
          CMD_DPD: if (all_idle) acc_dpd = 1'b1; else rej = 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign bank_close     = (acc_pre && !a10) || ((acc_rd || acc_wr) && a10);
  assign bank_close_all = acc_pre && a10;

  sdr_bank_track #(.BAW(BAW)) u_banks (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .open_i      (acc_act),
    .close_i     (bank_close),
    .close_all_i (bank_close_all),
    .bank_i      (ba_i),
    .active_o    (bank_open_o)
  );

  sdr_mode_regs #(.AW(AW), .MRD_CYC(MRD_CYC)) u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .din_i    (addr_i),
    .ld_mr_i  (acc_mr),
    .ld_emr_i (acc_emr),
    .forget_i (acc_dpd),
    .mr_ok_o  (mr_ok),
    .emr_ok_o (emr_ok),
    .mr_o     (mr_q),
    .emr_o    (emr_q),
    .busy_o   (busy),
    .ready_o  (ready)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_o <= 1'b0; pre_o <= 1'b0; rd_o <= 1'b0; wr_o <= 1'b0;
      load_o <= 1'b0; bad_o <= 1'b0; dpd_o <= 1'b0;
      bank_o <= '0; auto_pre_o <= 1'b0; all_banks_o <= 1'b0;
      col_o <= '0; row_o <= '0;
    end else begin
      act_o  <= acc_act;
      pre_o  <= acc_pre;
      rd_o   <= acc_rd;
      wr_o   <= acc_wr;
      load_o <= acc_mr || acc_emr;
      bad_o  <= rej;
      if (acc_dpd)             dpd_o <= 1'b1;
      else if (dpd_o && cke_i) dpd_o <= 1'b0;
      if (acc_act || acc_pre || acc_rd || acc_wr) begin
        bank_o      <= ba_i;
        auto_pre_o  <= (acc_rd || acc_wr) && a10;
        all_banks_o <= acc_pre && a10;
      end
      if (acc_act)          row_o <= addr_i;
      if (acc_rd || acc_wr) col_o <= addr_i[COLW-1:0];
    end
  end

  assign burst_len_o = mr_q[2:0];
  assign burst_ilv_o = mr_q[3];
  assign cas_lat_o   = mr_q[6:4];
  assign op_mode_o   = mr_q[8:7];
  assign wr_single_o = mr_q[9];
  assign pasr_o      = emr_q[2:0];
  assign temp_o      = emr_q[4:3];
  assign drive_o     = emr_q[6:5];

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({act_o, pre_o, rd_o, wr_o, load_o})); // R2

  AST_REJECT_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    bad_o |-> !(act_o || pre_o || rd_o || wr_o || load_o)); // R5

  AST_DESELECT_MASKS: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_n_i && cke_i) |=> !(act_o || pre_o || rd_o || wr_o || load_o || bad_o)); // R1

  AST_LOAD_ALL_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |-> (bank_open_o == '0)); // R8

  AST_ACCESS_KEEPS_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
    ((rd_o || wr_o) && !auto_pre_o) |-> bank_open_o[bank_o]); // R4

  AST_DPD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    dpd_o |-> (bank_open_o == '0)); // R11

  AST_DPD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (dpd_o && $past(dpd_o)) |-> !(act_o || pre_o || rd_o || wr_o || load_o || bad_o)); // R11

endmodule

// File: tb/sim_sdr_cmd_decoder.sv
`timescale 1ns/1ps
module sim_sdr_cmd_decoder;

  typedef struct packed {
    logic [4:0]  stb;   // act, pre, rd, wr, load
    logic        bad;
    logic        dpd;
    logic [3:0]  open;
    logic [9:0]  mr;
    logic [6:0]  emr;
    logic [1:0]  bank;
    logic        ap;
    logic        allb;
    logic [8:0]  col;
    logic [12:0] row;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;

  logic act, pre, rd, wr, load, bad, auto_pre, all_banks, dpd, burst_ilv, wr_single;
  logic [1:0] bank, op_mode, temp, drive;
  logic [8:0] col;
  logic [12:0] row;
  logic [3:0] bank_open;
  logic [2:0] burst_len, cas_lat, pasr;

  int checks = 0, errors = 0;
  exp_t  q[$];
  string tq[$];

  // reference state
  logic [3:0]  m_open = '0;
  logic [9:0]  m_mr = 10'h030;
  logic [6:0]  m_emr = 7'h18;
  logic [1:0]  m_bank = '0;
  logic        m_ap = 1'b0, m_allb = 1'b0, m_dpd = 1'b0, m_mrok = 1'b1, m_emrok = 1'b1;
  logic [8:0]  m_col = '0;
  logic [12:0] m_row = '0;
  int          m_busy = 0;

  always #4 clk = ~clk;

  sdr_cmd_decoder u0 (
    .clk_i(clk), .rst_i(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
    .act_o(act), .pre_o(pre), .rd_o(rd), .wr_o(wr), .load_o(load), .bad_o(bad),
    .bank_o(bank), .auto_pre_o(auto_pre), .all_banks_o(all_banks), .col_o(col),
    .row_o(row), .bank_open_o(bank_open), .burst_len_o(burst_len),
    .burst_ilv_o(burst_ilv), .cas_lat_o(cas_lat), .op_mode_o(op_mode),
    .wr_single_o(wr_single), .pasr_o(pasr), .temp_o(temp), .drive_o(drive),
    .dpd_o(dpd)
  );

  function automatic logic mr_legal(input logic [12:0] v);
    return (v[12:10] == 3'b0) && (v[8:7] == 2'b00) &&
           (v[6:4] == 3'd2 || v[6:4] == 3'd3) &&
           (v[2:0] <= 3'd3 || (v[2:0] == 3'd7 && !v[3]));
  endfunction

  function automatic logic emr_legal(input logic [12:0] v);
    return (v[12:7] == 6'b0) && (v[6:5] != 2'b11) &&
           (v[2:0] == 3'd0 || v[2:0] == 3'd1 || v[2:0] == 3'd2 ||
            v[2:0] == 3'd5 || v[2:0] == 3'd6);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // driver: applies one command and pushes the predicted result
  task automatic step(input logic k, input logic c, input logic r, input logic s,
                      input logic w, input logic [1:0] b, input logic [12:0] a, input string tag);
    exp_t e;
    int   kind;
    logic busy_now, ld;
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; addr = a;
    e = '0; ld = 1'b0;
    busy_now = (m_busy > 0);
    if (m_dpd) begin
      if (k) m_dpd = 1'b0;
    end else begin
      kind = 0;
      if (!k) begin
        if (!c && r && s && !w) kind = 6;
      end else if (!c) begin
        case ({r, s, w})
          3'b011: kind = 1;
          3'b010: kind = 2;
          3'b101: kind = 3;
          3'b100: kind = 4;
          3'b000: kind = 5;
          3'b111: kind = 0;
          default: kind = 7;
        endcase
      end
      if (kind != 0 && busy_now) e.bad = 1'b1;
      else case (kind)
        1: if (m_open[b]) e.bad = 1'b1;
           else begin e.stb[4] = 1'b1; m_open[b] = 1'b1; m_bank = b; m_row = a; m_ap = 0; m_allb = 0; end
        2: begin
             e.stb[3] = 1'b1; m_bank = b; m_ap = 0; m_allb = a[10];
             if (a[10]) m_open = '0; else m_open[b] = 1'b0;
           end
        3, 4: if (m_open[b] && m_mrok && m_emrok) begin
                if (kind == 3) e.stb[2] = 1'b1; else e.stb[1] = 1'b1;
                m_bank = b; m_col = a[8:0]; m_ap = a[10]; m_allb = 0;
                if (a[10]) m_open[b] = 1'b0;
              end else e.bad = 1'b1;
        5: if (m_open != '0) e.bad = 1'b1;
           else if (b == 2'b00 && mr_legal(a)) begin m_mr = a[9:0]; m_mrok = 1; ld = 1; e.stb[0] = 1'b1; end
           else if (b == 2'b10 && emr_legal(a)) begin m_emr = a[6:0]; m_emrok = 1; ld = 1; e.stb[0] = 1'b1; end
           else e.bad = 1'b1;
        6: if (m_open != '0) e.bad = 1'b1;
           else begin m_dpd = 1'b1; m_mrok = 0; m_emrok = 0; end
        default: ;
      endcase
    end
    if (ld) m_busy = 1;
    else if (m_busy > 0) m_busy--;
    e.dpd = m_dpd; e.open = m_open; e.mr = m_mr; e.emr = m_emr;
    e.bank = m_bank; e.ap = m_ap; e.allb = m_allb; e.col = m_col; e.row = m_row;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic t_nop(input string tag);  step(1, 0, 1, 1, 1, 2'd0, 13'd0, tag); endtask
  task automatic t_act(input logic [1:0] b, input logic [12:0] rw, input string tag);
    step(1, 0, 0, 1, 1, b, rw, tag); endtask
  task automatic t_pre(input logic [1:0] b, input logic all, input string tag);
    step(1, 0, 0, 1, 0, b, all ? 13'h400 : 13'h000, tag); endtask
  task automatic t_rd(input logic [1:0] b, input logic [8:0] cl, input logic ap, input string tag);
    step(1, 0, 1, 0, 1, b, {2'b00, ap, 1'b0, cl}, tag); endtask
  task automatic t_wr(input logic [1:0] b, input logic [8:0] cl, input logic ap, input string tag);
    step(1, 0, 1, 0, 0, b, {2'b00, ap, 1'b0, cl}, tag); endtask
  task automatic t_load(input logic [1:0] b, input logic [12:0] v, input string tag);
    step(1, 0, 0, 0, 0, b, v, tag); endtask

  // monitor: pops one prediction per cycle, after the edge has settled
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      chk(t, "strobes", {act, pre, rd, wr, load}, e.stb);
      chk(t, "illegal", bad, e.bad);
      chk(t, "dpd", dpd, e.dpd);
      chk(t, "open", bank_open, e.open);
      chk(t, "mr", {wr_single, op_mode, cas_lat, burst_ilv, burst_len}, e.mr);
      chk(t, "emr", {drive, temp, pasr}, e.emr);
      chk(t, "bank", bank, e.bank);
      chk(t, "flags", {auto_pre, all_banks}, {e.ap, e.allb});
      chk(t, "col", col, e.col);
      chk(t, "row", row, e.row);
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_nop("R7");                                  // reset values
    step(1, 1, 0, 1, 1, 2'd1, 13'h0AA, "R1");     // deselected activate
    step(1, 1, 1, 0, 0, 2'd0, 13'h400, "R1");     // deselected write
    t_act(2'd0, 13'h1ABC, "R2");
    t_act(2'd0, 13'h0123, "R5");                  // already open
    t_rd(2'd1, 9'h005, 1'b0, "R5");               // closed bank
    t_rd(2'd0, 9'h005, 1'b0, "R4");
    t_wr(2'd0, 9'h1FF, 1'b1, "R4");               // auto-precharge closes bank 0
    t_wr(2'd0, 9'h010, 1'b0, "R5");               // bank 0 now closed
    t_act(2'd1, 13'h0001, "R2");
    t_act(2'd2, 13'h1FFF, "R2");
    t_pre(2'd1, 1'b0, "R2");
    t_load(2'd0, 13'h02A, "R8");                  // bank 2 still open
    step(0, 0, 1, 1, 0, 2'd0, 13'd0, "R12");      // power-down refused
    t_pre(2'd3, 1'b1, "R3");
    t_load(2'd0, 13'h02A, "R6");
    t_act(2'd0, 13'h0042, "R10");                 // inside wait window
    t_act(2'd0, 13'h0042, "R10");                 // second edge: accepted
    t_pre(2'd0, 1'b0, "R2");
    t_load(2'd2, 13'h049, "R6");
    t_nop("R10");
    t_load(2'd1, 13'h030, "R6");                  // reserved select
    t_load(2'd3, 13'h030, "R6");
    t_load(2'd0, 13'h010, "R9");                  // latency 1
    t_load(2'd0, 13'h0B0, "R9");                  // operating mode 01
    t_load(2'd0, 13'h03F, "R9");                  // full page interleaved
    t_load(2'd0, 13'h034, "R9");                  // burst code 100
    t_load(2'd0, 13'h430, "R9");                  // high bit set
    t_load(2'd2, 13'h003, "R9");                  // coverage 011
    t_load(2'd2, 13'h060, "R9");                  // drive 11
    t_load(2'd2, 13'h080, "R9");                  // bit 7 set
    t_load(2'd0, 13'h237, "R6");                  // full page sequential, single writes
    t_nop("R10");
    step(1, 0, 0, 0, 1, 2'd0, 13'd0, "R2");       // refresh code: silent
    step(0, 0, 0, 1, 1, 2'd0, 13'd0, "R11");      // clock enable low, other code
    step(0, 0, 1, 1, 0, 2'd0, 13'd0, "R11");      // enter power-down
    step(0, 0, 0, 1, 1, 2'd1, 13'd5, "R11");      // ignored
    step(0, 1, 1, 1, 1, 2'd0, 13'd0, "R11");
    step(1, 0, 0, 1, 1, 2'd3, 13'h0777, "R11");   // exit edge, activate ignored
    t_act(2'd3, 13'h0777, "R13");
    t_rd(2'd3, 9'h00C, 1'b0, "R13");              // not reinitialised
    t_pre(2'd3, 1'b0, "R13");
    t_load(2'd0, 13'h030, "R13");
    t_nop("R13");
    t_act(2'd3, 13'h0777, "R13");
    t_wr(2'd3, 9'h00C, 1'b0, "R13");              // extended register still pending
    t_pre(2'd0, 1'b1, "R3");
    t_load(2'd2, 13'h018, "R13");
    t_nop("R13");
    t_act(2'd3, 13'h0100, "R13");
    t_rd(2'd3, 9'h0AB, 1'b0, "R13");              // now accepted
    t_wr(2'd3, 9'h0CD, 1'b1, "R4");
    step(1, 1, 1, 1, 1, 2'd0, 13'd0, "R1");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule